// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block is the command interpreter of a 16-bit-wide NOR flash device. The host bus hands it one write per clock: an address, a data word and a strobe. The block matches these writes against the device's multi-write command sequences. A two-write unlock pattern leads into most commands. Word program takes four writes and erase takes six. Write-buffer programming carries a word count and a series of loads. A bypass mode uses shortened sequences. The block also handles a secured-sector mode, ID and query read modes, and the suspend and resume commands.

The block keeps the current operating mode on a 3-bit output. When a sequence completes, the block emits a one-clock operation pulse with a kind code, the address and data of the write that finished it, and, for a buffer program, the word count. The array, the embedded algorithms and status polling sit outside the block. The `busy` input stands for an embedded algorithm that is running.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (read-array), `op_valid` is 0 and `buf_abort` is 0.
- R2: In the read-array mode, each write is one cycle. The writes AA at word address 555, then 55 at 2AA, then 90 at 555 set `mode` to 1 (ID read). In mode 1, only a write of F0 (at any address) takes the block back to mode 0. A prefix followed by any other code at 555 produces no pulse. It leaves the mode at 0, except for the codes named in R7, R9 and R10.
- R3: In mode 0, a single write of 98 at word address 55 sets `mode` to 2 (query). In mode 2, every write except F0 is ignored, and F0 returns the block to mode 0. A write of 98 at any other address does not enter mode 2.
- R4: Word program is the unlock prefix, then A0 at 555, then a write at the target. One clock after that fourth write, `op_valid` is 1 for exactly one cycle. At the same time, `op_kind` is 1 and `op_addr`/`op_data` carry the target write.
- R5: Erase is the prefix, then 80 at 555, then the prefix again, then a final write. If the final write is 10 at 555, the pulse has `op_kind`=2 (chip erase). If it is 30 at any address, the pulse has `op_kind`=3 (sector erase) and `op_addr` set to that address.
- R6: A write that breaks a sequence outside the buffer states returns the block to idle with no pulse. The mode is left unchanged, and the next write must start a sequence from its first cycle.
- R7: Buffer program runs as follows. The prefix comes first, then 25 at a sector address S (bits 16 and up name the sector), which sets `mode` to 4. Next comes N-1 written at S. Then N loads follow, each pulsing `op_kind`=4 with its address and data. Last comes 29 at S, which pulses `op_kind`=5 with `op_count`=N-1 and returns `mode` to 0.
- R8: In the buffer states, certain writes raise `buf_abort` and issue no pulse. These are: a word count of 2^CNT_W or more; a count, load or confirm outside sector S; a load outside the 2^CNT_W-word page of the first load; and a confirm code other than 29. `buf_abort` then stays high with `mode` 4 until the block sees AA at 555, 55 at 2AA and F0, in that order.
- R9: The prefix then 20 at 555 sets `mode` to 3 (bypass). In bypass, A0 followed by a data write pulses program. 80 followed by 10 pulses chip erase, and 80 followed by 30 pulses sector erase. F0 is ignored. 90 followed by 00 returns the block to mode 0.
- R10: The prefix then 88 at 555 sets `mode` to 5 (secured sector). Program sequences still work in this mode. The prefix, then 90 at 555, then 00 returns the block to mode 0.
- R11: While `busy` is 1, only a write with low byte B0 has an effect. It pulses `op_kind`=6 and sets `mode` to 6 (suspended). In mode 6 with `busy` low, only a write of 30 has an effect. It pulses `op_kind`=7 and restores the previous mode.
- R12: On unlock and command writes, data bits 15..8 and address bits 16 and up are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Data word of the write |
| busy | input | 1 | An embedded operation is running |
| mode | output | 3 | 0 read, 1 ID, 2 query, 3 bypass, 4 buffer, 5 secured, 6 suspended |
| op_valid | output | 1 | One-cycle operation pulse |
| op_kind | output | 3 | 1 program, 2 chip erase, 3 sector erase, 4 buffer load, 5 buffer commit, 6 suspend, 7 resume |
| op_addr | output | ADDR_W | Address of the write that completed the operation |
| op_data | output | DATA_W | Data of the write that completed the operation |
| op_count | output | CNT_W | Buffer word count minus one, valid with kind 5 |
| buf_abort | output | 1 | Buffer sequence aborted, awaiting abort reset |

## Verification
A wrong sequence position is not visible on `mode` until the write that should finish or break the sequence. From that write on, a wrong position shows up one clock later as a missing, extra or wrongly coded pulse. A wrong mode register shows up directly on `mode` one clock after the write that changed it. A buffer tracker that has lost its count moves the commit pulse to another write, or raises `buf_abort` at the confirm. The exhaustive sweep over every code after the unlock prefix therefore exposes any wrong decode within two writes.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    MD_READ    = 3'd0,
    MD_IDREAD  = 3'd1,
    MD_QUERY   = 3'd2,
    MD_BYPASS  = 3'd3,
    MD_BUFFER  = 3'd4,
    MD_SECURE  = 3'd5,
    MD_SUSPEND = 3'd6
  } mode_e;

  typedef enum logic [2:0] {
    OP_NONE       = 3'd0,
    OP_PROGRAM    = 3'd1,
    OP_CHIP_ERASE = 3'd2,
    OP_SECT_ERASE = 3'd3,
    OP_BUF_LOAD   = 3'd4,
    OP_BUF_COMMIT = 3'd5,
    OP_SUSPEND    = 3'd6,
    OP_RESUME     = 3'd7
  } op_e;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_UNL1,
    SQ_UNL2,
    SQ_PROG,
    SQ_ER_U1,
    SQ_ER_U2,
    SQ_ER_CMD,
    SQ_BUF_CNT,
    SQ_BUF_LOAD,
    SQ_BUF_CONF,
    SQ_ABT0,
    SQ_ABT1,
    SQ_ABT2,
    SQ_BYP_PROG,
    SQ_BYP_ER,
    SQ_EXIT
  } seq_e;

  localparam logic [7:0] C_UNL1    = 8'hAA;
  localparam logic [7:0] C_UNL2    = 8'h55;
  localparam logic [7:0] C_RESET   = 8'hF0;
  localparam logic [7:0] C_IDREAD  = 8'h90;
  localparam logic [7:0] C_QUERY   = 8'h98;
  localparam logic [7:0] C_PROG    = 8'hA0;
  localparam logic [7:0] C_ERASE   = 8'h80;
  localparam logic [7:0] C_CHIP    = 8'h10;
  localparam logic [7:0] C_SECT    = 8'h30;
  localparam logic [7:0] C_BUFWR   = 8'h25;
  localparam logic [7:0] C_BUFCONF = 8'h29;
  localparam logic [7:0] C_BYPASS  = 8'h20;
  localparam logic [7:0] C_SECURE  = 8'h88;
  localparam logic [7:0] C_SUSP    = 8'hB0;
  localparam logic [7:0] C_RESUME  = 8'h30;
  localparam logic [7:0] C_EXIT    = 8'h00;

endpackage

// File: rtl/flash_cmd_classify.sv
module flash_cmd_classify #(
  parameter int ADDR_W   = 22,
  parameter int SECT_LSB = 16,
  parameter int CNT_W    = 5,
  localparam int SECT_W  = ADDR_W - SECT_LSB,
  localparam int PAGE_W  = ADDR_W - CNT_W
) (
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        code,
  output logic              hit_a,
  output logic              hit_query,
  output logic              unlock1,
  output logic              unlock2,
  output logic [SECT_W-1:0] sector,
  output logic [PAGE_W-1:0] page
);
  import flash_cmd_pkg::*;

  localparam logic [SECT_LSB-1:0] ADR_A = SECT_LSB'(12'h555);
  localparam logic [SECT_LSB-1:0] ADR_B = SECT_LSB'(12'h2AA);
  localparam logic [SECT_LSB-1:0] ADR_Q = SECT_LSB'(12'h055);

  logic [SECT_LSB-1:0] low_addr;
  logic                hit_b;

  always_comb begin
    low_addr  = wr_addr[SECT_LSB-1:0];
    hit_a     = (low_addr == ADR_A);
    hit_b     = (low_addr == ADR_B);
    hit_query = (low_addr == ADR_Q);
    unlock1   = hit_a && (code == C_UNL1);
    unlock2   = hit_b && (code == C_UNL2);
    sector    = wr_addr[ADDR_W-1:SECT_LSB];
    page      = wr_addr[ADDR_W-1:CNT_W];
  end

endmodule

// File: rtl/flash_cmd_buftrack.sv
module flash_cmd_buftrack #(
  parameter int ADDR_W   = 22,
  parameter int SECT_LSB = 16,
  parameter int CNT_W    = 5,
  localparam int SECT_W  = ADDR_W - SECT_LSB,
  localparam int PAGE_W  = ADDR_W - CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              set_cnt,
  input  logic              load,
  input  logic [SECT_W-1:0] sector,
  input  logic [PAGE_W-1:0] page,
  input  logic [CNT_W-1:0]  wc_in,
  output logic              sector_hit,
  output logic              page_hit,
  output logic              last_load,
  output logic [CNT_W-1:0]  wc_q
);

  logic [SECT_W-1:0] sect_q;
  logic [PAGE_W-1:0] page_q;
  logic              page_vld_q;
  logic [CNT_W-1:0]  left_q;

  logic [PAGE_W-1:0] page_d;
  logic              page_vld_d;
  logic [CNT_W-1:0]  left_d;
  logic [CNT_W-1:0]  wc_d;
  logic [SECT_W-1:0] sect_d;

  always_comb begin
    sector_hit = (sector == sect_q);
    page_hit   = !page_vld_q || (page == page_q);
    last_load  = (left_q == '0);
  end

  always_comb begin
    sect_d     = sect_q;
    page_d     = page_q;
    page_vld_d = page_vld_q;
    left_d     = left_q;
    wc_d       = wc_q;
    if (start) begin
      sect_d = sector;
    end
    if (set_cnt) begin
      wc_d       = wc_in;
      left_d     = wc_in;
      page_vld_d = 1'b0;
    end else if (load) begin
      page_d     = page;
      page_vld_d = 1'b1;
      left_d     = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sect_q     <= '0;
      page_q     <= '0;
      page_vld_q <= 1'b0;
      left_q     <= '0;
      wc_q       <= '0;
    end else begin
      if (start) begin
        sect_q <= sect_d;
      end
      if (set_cnt || load) begin
        page_q     <= page_d;
        page_vld_q <= page_vld_d;
        left_q     <= left_d;
        wc_q       <= wc_d;
      end
    end
  end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              busy,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hit_a,
  input  logic              hit_query,
  input  logic              unlock1,
  input  logic              unlock2,
  input  logic              sector_hit,
  input  logic              page_hit,
  input  logic              last_load,
  input  logic [CNT_W-1:0]  wc_q,
  output logic              buf_start,
  output logic              buf_setcnt,
  output logic              buf_load,
  output logic [2:0]        mode,
  output logic              op_valid,
  output logic [2:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic [CNT_W-1:0]  op_count,
  output logic              buf_abort
);
  import flash_cmd_pkg::*;

  seq_e  seq_q, seq_d;
  mode_e base_q, base_d;
  logic  susp_q, susp_d;
  logic  abort_q, abort_d;
  op_e   kind_d;
  op_e   kind_q;
  logic  valid_q;
  logic  [ADDR_W-1:0] addr_q;
  logic  [DATA_W-1:0] data_q;
  logic  [CNT_W-1:0]  count_q, count_d;
  logic  [7:0]        code;
  logic               wc_ok;
  logic               fire;

  assign code  = wr_data[7:0];
  assign wc_ok = (wr_data[DATA_W-1:CNT_W] == '0);

  always_comb begin
    seq_d      = seq_q;
    base_d     = base_q;
    susp_d     = susp_q;
    abort_d    = abort_q;
    kind_d     = OP_NONE;
    count_d    = '0;
    buf_start  = 1'b0;
    buf_setcnt = 1'b0;
    buf_load   = 1'b0;
    if (wr_en) begin
      if (busy) begin
        if ((code == C_SUSP) && !susp_q) begin
          kind_d = OP_SUSPEND;
          susp_d = 1'b1;
        end
      end else if (susp_q) begin
        if (code == C_RESUME) begin
          kind_d = OP_RESUME;
          susp_d = 1'b0;
        end
      end else begin
        case (seq_q)
          SQ_IDLE: begin
            case (base_q)
              MD_BYPASS: begin
                if (code == C_PROG)         seq_d = SQ_BYP_PROG;
                else if (code == C_ERASE)   seq_d = SQ_BYP_ER;
                else if (code == C_IDREAD)  seq_d = SQ_EXIT;
              end
              MD_IDREAD, MD_QUERY: begin
                if (code == C_RESET) base_d = MD_READ;
              end
              default: begin
                if (unlock1) begin
                  seq_d = SQ_UNL1;
                end else if ((base_q == MD_READ) && hit_query && (code == C_QUERY)) begin
                  base_d = MD_QUERY;
                end
              end
            endcase
          end
          SQ_UNL1: seq_d = unlock2 ? SQ_UNL2 : SQ_IDLE;
          SQ_UNL2: begin
            seq_d = SQ_IDLE;
            if (code == C_BUFWR) begin
              seq_d     = SQ_BUF_CNT;
              buf_start = 1'b1;
            end else if (hit_a) begin
              case (code)
                C_PROG:   seq_d = SQ_PROG;
                C_ERASE:  seq_d = SQ_ER_U1;
                C_IDREAD: begin
                  if (base_q == MD_SECURE) seq_d  = SQ_EXIT;
                  else                     base_d = MD_IDREAD;
                end
                C_BYPASS: begin
                  if (base_q == MD_READ) base_d = MD_BYPASS;
                end
                C_SECURE: base_d = MD_SECURE;
                default:  seq_d = SQ_IDLE;
              endcase
            end
          end
          SQ_PROG: begin
            kind_d = OP_PROGRAM;
            seq_d  = SQ_IDLE;
          end
          SQ_ER_U1: seq_d = unlock1 ? SQ_ER_U2 : SQ_IDLE;
          SQ_ER_U2: seq_d = unlock2 ? SQ_ER_CMD : SQ_IDLE;
          SQ_ER_CMD, SQ_BYP_ER: begin
            seq_d = SQ_IDLE;
            if ((code == C_CHIP) && (hit_a || (seq_q == SQ_BYP_ER))) kind_d = OP_CHIP_ERASE;
            else if (code == C_SECT)                                 kind_d = OP_SECT_ERASE;
          end
          SQ_BUF_CNT: begin
            if (sector_hit && wc_ok) begin
              seq_d      = SQ_BUF_LOAD;
              buf_setcnt = 1'b1;
            end else begin
              seq_d   = SQ_ABT0;
              abort_d = 1'b1;
            end
          end
          SQ_BUF_LOAD: begin
            if (sector_hit && page_hit) begin
              buf_load = 1'b1;
              kind_d   = OP_BUF_LOAD;
              if (last_load) seq_d = SQ_BUF_CONF;
            end else begin
              seq_d   = SQ_ABT0;
              abort_d = 1'b1;
            end
          end
          SQ_BUF_CONF: begin
            if (sector_hit && (code == C_BUFCONF)) begin
              kind_d  = OP_BUF_COMMIT;
              count_d = wc_q;
              seq_d   = SQ_IDLE;
            end else begin
              seq_d   = SQ_ABT0;
              abort_d = 1'b1;
            end
          end
          SQ_ABT0: seq_d = unlock1 ? SQ_ABT1 : SQ_ABT0;
          SQ_ABT1: seq_d = unlock2 ? SQ_ABT2 : SQ_ABT0;
          SQ_ABT2: begin
            if (code == C_RESET) begin
              seq_d   = SQ_IDLE;
              abort_d = 1'b0;
            end else begin
              seq_d = SQ_ABT0;
            end
          end
          SQ_BYP_PROG: begin
            kind_d = OP_PROGRAM;
            seq_d  = SQ_IDLE;
          end
          SQ_EXIT: begin
            seq_d = SQ_IDLE;
            if (code == C_EXIT) base_d = MD_READ;
          end
          default: seq_d = SQ_IDLE;
        endcase
      end
    end
  end

  assign fire = (kind_d != OP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q   <= SQ_IDLE;
      base_q  <= MD_READ;
      susp_q  <= 1'b0;
      abort_q <= 1'b0;
      valid_q <= 1'b0;
      kind_q  <= OP_NONE;
      addr_q  <= '0;
      data_q  <= '0;
      count_q <= '0;
    end else begin
      seq_q   <= seq_d;
      base_q  <= base_d;
      susp_q  <= susp_d;
      abort_q <= abort_d;
      valid_q <= fire;
      kind_q  <= kind_d;
      if (fire) begin
        addr_q  <= wr_addr;
        data_q  <= wr_data;
        count_q <= count_d;
      end
    end
  end

  always_comb begin
    if (susp_q) begin
      mode = MD_SUSPEND;
    end else begin
      case (seq_q)
        SQ_BUF_CNT, SQ_BUF_LOAD, SQ_BUF_CONF,
        SQ_ABT0, SQ_ABT1, SQ_ABT2: mode = MD_BUFFER;
        default:                   mode = base_q;
      endcase
    end
  end

  assign op_valid  = valid_q;
  assign op_kind   = kind_q;
  assign op_addr   = addr_q;
  assign op_data   = data_q;
  assign op_count  = count_q;
  assign buf_abort = abort_q;

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 16,
  parameter int SECT_LSB  = 16,
  parameter int BUF_WORDS = 32,
  localparam int CNT_W    = $clog2(BUF_WORDS),
  localparam int SECT_W   = ADDR_W - SECT_LSB,
  localparam int PAGE_W   = ADDR_W - CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic [2:0]        mode,
  output logic              op_valid,
  output logic [2:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic [CNT_W-1:0]  op_count,
  output logic              buf_abort
);

  logic              hit_a, hit_query, unlock1, unlock2;
  logic [SECT_W-1:0] sector;
  logic [PAGE_W-1:0] page;
  logic              sector_hit, page_hit, last_load;
  logic [CNT_W-1:0]  wc_q;
  logic              buf_start, buf_setcnt, buf_load;

  flash_cmd_classify #(
    .ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB), .CNT_W(CNT_W)
  ) u_class (
    .wr_addr   (wr_addr),
    .code      (wr_data[7:0]),
    .hit_a     (hit_a),
    .hit_query (hit_query),
    .unlock1   (unlock1),
    .unlock2   (unlock2),
    .sector    (sector),
    .page      (page)
  );

  flash_cmd_buftrack #(
    .ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB), .CNT_W(CNT_W)
  ) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (buf_start),
    .set_cnt    (buf_setcnt),
    .load       (buf_load),
    .sector     (sector),
    .page       (page),
    .wc_in      (wr_data[CNT_W-1:0]),
    .sector_hit (sector_hit),
    .page_hit   (page_hit),
    .last_load  (last_load),
    .wc_q       (wc_q)
  );

  flash_cmd_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .busy       (busy),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .hit_a      (hit_a),
    .hit_query  (hit_query),
    .unlock1    (unlock1),
    .unlock2    (unlock2),
    .sector_hit (sector_hit),
    .page_hit   (page_hit),
    .last_load  (last_load),
    .wc_q       (wc_q),
    .buf_start  (buf_start),
    .buf_setcnt (buf_setcnt),
    .buf_load   (buf_load),
    .mode       (mode),
    .op_valid   (op_valid),
    .op_kind    (op_kind),
    .op_addr    (op_addr),
    .op_data    (op_data),
    .op_count   (op_count),
    .buf_abort  (buf_abort)
  );

endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_code,
  input logic       busy,
  input logic [2:0] mode,
  input logic       op_valid,
  input logic [2:0] op_kind,
  input logic       buf_abort
);

  AST_OP_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> $past(wr_en)); // R4

  AST_ABORT_IN_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
    buf_abort |-> (mode == 3'd4 || mode == 3'd6)); // R8

  AST_ABORT_CLEARS_ON_F0: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_abort) |-> ($past(wr_en) && $past(wr_code) == 8'hF0)); // R8

  AST_BUSY_ONLY_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && op_valid) |-> (op_kind == 3'd6)); // R11

  AST_RESUME_FROM_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 3'd7) |-> ($past(mode) == 3'd6)); // R11

  AST_QUERY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode == 3'd2) |-> ($past(wr_en) && $past(wr_code) == 8'h98)); // R3

endmodule

bind flash_cmd_decoder flash_cmd_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_code   (wr_data[7:0]),
  .busy      (busy),
  .mode      (mode),
  .op_valid  (op_valid),
  .op_kind   (op_kind),
  .buf_abort (buf_abort)
);

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int BW = 8;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          busy = 1'b0;
  logic [2:0]    mode;
  logic          op_valid;
  logic [2:0]    op_kind;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic [CW-1:0] op_count;
  logic          buf_abort;

  int total = 0;
  int fails = 0;

  logic [2:0]    s_mode, s_kind;
  logic          s_v, s_abort;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_data;
  logic [CW-1:0] s_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW), .SECT_LSB(16), .BUF_WORDS(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .mode(mode), .op_valid(op_valid), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data), .op_count(op_count), .buf_abort(buf_abort)
  );

  task automatic snap();
    s_mode = mode; s_v = op_valid; s_kind = op_kind; s_addr = op_addr;
    s_data = op_data; s_cnt = op_count; s_abort = buf_abort;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    snap();
    wr_en = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    snap();
  endtask

  task automatic unlock();
    wr(20'h00555, 16'h00AA);
    wr(20'h002AA, 16'h0055);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_nop(input string req);
    chk(req, "no pulse", {31'd0, s_v}, 32'd0);
  endtask

  task automatic chk_op(input string req, input logic [2:0] k, input logic [AW-1:0] a, input logic [DW-1:0] d);
    chk(req, "op_valid", {31'd0, s_v}, 32'd1);
    chk(req, "op_kind", {29'd0, s_kind}, {29'd0, k});
    chk(req, "op_addr", {12'd0, s_addr}, {12'd0, a});
    chk(req, "op_data", {16'd0, s_data}, {16'd0, d});
  endtask

  task automatic chk_mode(input string req, input logic [2:0] m);
    chk(req, "mode", {29'd0, s_mode}, {29'd0, m});
  endtask

  task automatic clear_abort();
    unlock();
    wr(20'h00000, 16'h00F0);
  endtask

  function automatic logic [2:0] sweep_mode(input int c);
    case (c)
      8'h90: return 3'd1;
      8'h20: return 3'd3;
      8'h88: return 3'd5;
      8'h25: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle();
    // R1 reset state
    chk_mode("R1", 3'd0);
    chk("R1", "op_valid", {31'd0, s_v}, 32'd0);
    chk("R1", "buf_abort", {31'd0, s_abort}, 32'd0);

    // R2 R6 R9 R10: every code after the unlock prefix
    for (int c = 0; c < 256; c++) begin
      unlock();
      wr(20'h00555, 16'(c));
      chk_mode("R2", sweep_mode(c));
      chk_nop("R6");
      case (c)
        8'h90: wr(20'h00000, 16'h00F0);
        8'h20: begin wr(20'h00000, 16'h0090); wr(20'h00000, 16'h0000); end
        8'h88: begin unlock(); wr(20'h00555, 16'h0090); wr(20'h00000, 16'h0000); end
        8'h25: begin
          wr(20'h00555, 16'h0100);
          chk("R8", "abort on big count", {31'd0, s_abort}, 32'd1);
          clear_abort();
          chk("R8", "abort cleared", {31'd0, s_abort}, 32'd0);
        end
        8'hA0: begin
          wr(20'h00123, 16'h4567);
          chk_op("R4", 3'd1, 20'h00123, 16'h4567);
        end
        8'h80: wr(20'h00000, 16'h00F0);
        default: ;
      endcase
      idle();
      chk_mode("R6", 3'd0);
    end

    // R3 query mode
    wr(20'h00056, 16'h0098);
    chk_mode("R3", 3'd0);
    wr(20'h00055, 16'h0098);
    chk_mode("R3", 3'd2);
    unlock();
    wr(20'h00555, 16'h00A0);
    wr(20'h00100, 16'h1111);
    chk_nop("R3");
    chk_mode("R3", 3'd2);
    wr(20'h00000, 16'h00F0);
    chk_mode("R3", 3'd0);

    // R4 R12 program with upper bits set on command cycles
    for (int i = 0; i < 6; i++) begin
      logic [AW-1:0] ta;
      logic [DW-1:0] td;
      ta = AW'(20'h4ABCD + i * 20'h1357);
      td = DW'(16'h9876 ^ (i * 16'h1111));
      wr(AW'(20'hF0555 - i * 20'h10000), 16'h12AA);
      wr(20'hA02AA, 16'hFF55);
      wr(20'h30555, 16'h77A0);
      chk_nop("R12");
      wr(ta, td);
      chk_op("R12", 3'd1, ta, td);
      idle();
      chk("R4", "pulse one cycle", {31'd0, s_v}, 32'd0);
    end

    // R5 erase
    unlock(); wr(20'h00555, 16'h0080); unlock();
    wr(20'h00555, 16'h0010);
    chk_op("R5", 3'd2, 20'h00555, 16'h0010);
    unlock(); wr(20'h00555, 16'h0080); unlock();
    wr(20'h30000, 16'h0030);
    chk_op("R5", 3'd3, 20'h30000, 16'h0030);

    // R6 broken prefix
    wr(20'h00555, 16'h00AA);
    wr(20'h002AB, 16'h0055);
    wr(20'h00555, 16'h00A0);
    wr(20'h00100, 16'h0055);
    chk_nop("R6");
    chk_mode("R6", 3'd0);

    // R7 buffer program for every count
    for (int wc = 0; wc < BW; wc++) begin
      unlock();
      wr(20'h20000, 16'h0025);
      chk_mode("R7", 3'd4);
      wr(20'h20000, 16'(wc));
      for (int i = 0; i <= wc; i++) begin
        wr(AW'(20'h20010 + i), DW'(16'hB000 + wc * 16 + i));
        chk_op("R7", 3'd4, AW'(20'h20010 + i), DW'(16'hB000 + wc * 16 + i));
      end
      wr(20'h2ABCD, 16'h0029);
      chk_op("R7", 3'd5, 20'h2ABCD, 16'h0029);
      chk("R7", "op_count", {29'd0, s_cnt}, 32'(wc));
      chk_mode("R7", 3'd0);
    end

    // R8 page violation, held abort, clear
    unlock(); wr(20'h20000, 16'h0025); wr(20'h20000, 16'h0002);
    wr(20'h20010, 16'h0001);
    wr(20'h20018, 16'h0002);
    chk_nop("R8");
    chk("R8", "abort page", {31'd0, s_abort}, 32'd1);
    wr(20'h00555, 16'h00A0);
    unlock();
    wr(20'h00555, 16'h0090);
    chk("R8", "abort held", {31'd0, s_abort}, 32'd1);
    chk_mode("R8", 3'd4);
    clear_abort();
    chk("R8", "abort cleared", {31'd0, s_abort}, 32'd0);
    chk_mode("R8", 3'd0);
    // sector violation on load
    unlock(); wr(20'h20000, 16'h0025); wr(20'h20000, 16'h0000);
    wr(20'h30010, 16'h0001);
    chk("R8", "abort sector", {31'd0, s_abort}, 32'd1);
    clear_abort();
    // wrong confirm code
    unlock(); wr(20'h20000, 16'h0025); wr(20'h20000, 16'h0000);
    wr(20'h20010, 16'h0001);
    wr(20'h20000, 16'h0028);
    chk_nop("R8");
    chk("R8", "abort confirm", {31'd0, s_abort}, 32'd1);
    clear_abort();
    chk_mode("R8", 3'd0);

    // R9 bypass
    unlock(); wr(20'h00555, 16'h0020);
    chk_mode("R9", 3'd3);
    wr(20'h00000, 16'h00A0); wr(20'h01234, 16'hCAFE);
    chk_op("R9", 3'd1, 20'h01234, 16'hCAFE);
    wr(20'h00000, 16'h0080); wr(20'h00000, 16'h0010);
    chk_op("R9", 3'd2, 20'h00000, 16'h0010);
    wr(20'h00000, 16'h0080); wr(20'h50000, 16'h0030);
    chk_op("R9", 3'd3, 20'h50000, 16'h0030);
    wr(20'h00000, 16'h00F0);
    chk_mode("R9", 3'd3);
    wr(20'h00000, 16'h0090); wr(20'h00000, 16'h0000);
    chk_mode("R9", 3'd0);

    // R10 secured sector
    unlock(); wr(20'h00555, 16'h0088);
    chk_mode("R10", 3'd5);
    unlock(); wr(20'h00555, 16'h00A0); wr(20'h00042, 16'h0BEE);
    chk_op("R10", 3'd1, 20'h00042, 16'h0BEE);
    unlock(); wr(20'h00555, 16'h0090);
    chk_mode("R10", 3'd5);
    wr(20'h00000, 16'h0000);
    chk_mode("R10", 3'd0);

    // R11 busy, suspend, resume
    busy = 1'b1;
    unlock(); wr(20'h00555, 16'h00A0); wr(20'h00100, 16'h1234);
    chk_nop("R11");
    chk_mode("R11", 3'd0);
    wr(20'h00321, 16'h00B0);
    chk_op("R11", 3'd6, 20'h00321, 16'h00B0);
    chk_mode("R11", 3'd6);
    wr(20'h00000, 16'h00B0);
    chk_nop("R11");
    busy = 1'b0;
    wr(20'h00555, 16'h00AA);
    chk_nop("R11");
    chk_mode("R11", 3'd6);
    wr(20'h00777, 16'h0030);
    chk_op("R11", 3'd7, 20'h00777, 16'h0030);
    chk_mode("R11", 3'd0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule